// File: doc/BRIEF.md
# Cross-Processor Mailbox Sync Register

This block couples two 16-bit synchronisation registers, one per processor, so that each processor can post a 4-bit status code to the other and ring the other's doorbell interrupt. Each side has its own bus port with a write strobe, two byte enables, 16-bit write data and 16-bit read data. Each side also has one doorbell output aimed at its peer.

A side's register holds three things. Bit 14 is that side's doorbell-accept enable. Bits 11:8 hold its outgoing code. Bits 3:0 hold the incoming code, which is a read-only copy of the peer's outgoing code. When one side writes, its own enable and outgoing code are updated, and the new outgoing code appears at once in the peer's incoming field. If the written value has bit 13 set and the peer accepts doorbells, a one-cycle request pulse is sent toward the peer. Partial writes are merged per byte with the register's current readable contents before any of this happens.

Top module: `ipcsync_pair`

## Requirements
- R1: After reset both read words are 0x0000 and both doorbell outputs are low.
- R2: Only bit 14 and bits 11:8 of a merged write are stored; written bits 15, 12 and 7:4 are ignored and always read as 0.
- R3: Bits 3:0 of a side's read word are never changed by that side's own writes.
- R4: One clock after a write, the peer's bits 3:0 equal bits 11:8 of the merged write. The peer's bit 14 and bits 11:8 are unchanged.
- R5: A side's doorbell output is high for exactly the one cycle after a clock edge that accepted a write from that side with merged bit 13 set while the peer's bit 14 read as 1 before that edge. In all other cycles it is low.
- R6: Byte enable bit 1 selects the written high byte (bits 15:8) and byte enable bit 0 the written low byte. A byte whose enable is 0 takes the side's current read value, so a low-byte-only write leaves bit 14 and bits 11:8 unchanged and never rings the doorbell.
- R7: Bit 13 is a trigger only. It is never stored and always reads as 0.
- R8: When both sides write on the same edge, each side's enable, outgoing code and incoming code all take their new values, and each doorbell is decided from the peer's enable as it was before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_wr | input | 1 | Side A write strobe |
| a_be | input | 2 | Side A byte enables (bit 1 = bits 15:8) |
| a_wdata | input | 16 | Side A write data |
| a_rdata | output | 16 | Side A register view |
| a_ring | output | 1 | Doorbell request from A toward B |
| b_wr | input | 1 | Side B write strobe |
| b_be | input | 2 | Side B byte enables (bit 1 = bits 15:8) |
| b_wdata | input | 16 | Side B write data |
| b_rdata | output | 16 | Side B register view |
| b_ring | output | 1 | Doorbell request from B toward A |

## Verification
The assertions check several properties on every cycle. Reserved and trigger bits read as zero. The incoming nibble changes only when the peer writes. After a write, the peer's nibble equals the merged outgoing code. Any doorbell pulse can be traced back to a qualifying write and the peer's enable before it. The bench's scenarios are needed to show that the stored fields take the exact merged values for every byte-enable combination, that a low-byte-only write cannot ring, that simultaneous writes from both sides lose nothing, and that a reset in the middle of a run clears everything.

// File: rtl/ipcsync_pkg.sv
package ipcsync_pkg;
    parameter int DATA_W   = 16;
    parameter int BYTE_W   = 8;
    parameter int NIB_W    = 4;
    parameter int NSIDE    = 2;
    parameter int IEN_BIT  = 14;
    parameter int SEND_BIT = 13;
    parameter int OUT_LSB  = 8;
    parameter int IN_LSB   = 0;
    localparam int NBYTE   = DATA_W / BYTE_W;

    typedef struct packed {
        logic             ien;
        logic [NIB_W-1:0] onib;
        logic [NIB_W-1:0] inib;
    } side_t;

    typedef struct packed {
        side_t [NSIDE-1:0] side;
        logic  [NSIDE-1:0] ring;
    } state_t;
endpackage

// File: rtl/ipcsync_merge.sv
module ipcsync_merge #(
    parameter int DATA_W = 16,
    parameter int BYTE_W = 8,
    localparam int NBYTE = DATA_W / BYTE_W
) (
    input  logic [NBYTE-1:0]  be,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] cur,
    output logic [DATA_W-1:0] merged
);
    for (genvar g = 0; g < NBYTE; g++) begin : g_lane
        assign merged[g*BYTE_W +: BYTE_W] = be[g] ? wdata[g*BYTE_W +: BYTE_W]
                                                  : cur[g*BYTE_W +: BYTE_W];
    end
endmodule

// File: rtl/ipcsync_view.sv
module ipcsync_view
    import ipcsync_pkg::*;
(
    input  side_t             st,
    output logic [DATA_W-1:0] word
);
    always_comb begin
        word                     = '0;
        word[IEN_BIT]            = st.ien;
        word[OUT_LSB +: NIB_W]   = st.onib;
        word[IN_LSB +: NIB_W]    = st.inib;
    end
endmodule

// File: rtl/ipcsync_pair.sv
module ipcsync_pair
    import ipcsync_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_wr,
    input  logic [NBYTE-1:0]  a_be,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    output logic              a_ring,
    input  logic              b_wr,
    input  logic [NBYTE-1:0]  b_be,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_rdata,
    output logic              b_ring
);
    state_t st_d, st_q;

    logic [NSIDE-1:0]             wr;
    logic [NSIDE-1:0][NBYTE-1:0]  be;
    logic [NSIDE-1:0][DATA_W-1:0] wd;
    logic [NSIDE-1:0][DATA_W-1:0] view;
    logic [NSIDE-1:0][DATA_W-1:0] merged;

    assign wr = {b_wr, a_wr};
    assign be = {b_be, a_be};
    assign wd = {b_wdata, a_wdata};

    for (genvar s = 0; s < NSIDE; s++) begin : g_side
        ipcsync_view u_view (
            .st   (st_q.side[s]),
            .word (view[s])
        );
        ipcsync_merge #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_merge (
            .be     (be[s]),
            .wdata  (wd[s]),
            .cur    (view[s]),
            .merged (merged[s])
        );
    end

    always_comb begin
        st_d      = st_q;
        st_d.ring = '0;
        for (int s = 0; s < NSIDE; s++) begin
            if (wr[s]) begin
                st_d.side[s].ien                = merged[s][IEN_BIT];
                st_d.side[s].onib               = merged[s][OUT_LSB +: NIB_W];
                st_d.side[NSIDE-1-s].inib       = merged[s][OUT_LSB +: NIB_W];
                st_d.ring[s] = merged[s][SEND_BIT] & st_q.side[NSIDE-1-s].ien;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign a_rdata = view[0];
    assign b_rdata = view[1];
    assign a_ring  = st_q.ring[0];
    assign b_ring  = st_q.ring[1];

    logic unused_bits;
    assign unused_bits = ^{merged[0][DATA_W-1], merged[0][12], merged[0][OUT_LSB-1:0],
                           merged[1][DATA_W-1], merged[1][12], merged[1][OUT_LSB-1:0]};
endmodule

// File: rtl/ipcsync_pair_chk.sv
module ipcsync_pair_chk
    import ipcsync_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              a_wr,
    input logic [NBYTE-1:0]  a_be,
    input logic [DATA_W-1:0] a_wdata,
    input logic [DATA_W-1:0] a_rdata,
    input logic              a_ring,
    input logic              b_wr,
    input logic [NBYTE-1:0]  b_be,
    input logic [DATA_W-1:0] b_wdata,
    input logic [DATA_W-1:0] b_rdata,
    input logic              b_ring
);
    // R2
    a_rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_rdata[15] == 1'b0) && (a_rdata[12] == 1'b0) && (a_rdata[7:4] == 4'h0));
    // R2
    b_rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (b_rdata[15] == 1'b0) && (b_rdata[12] == 1'b0) && (b_rdata[7:4] == 4'h0));
    // R7
    send_bit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_rdata[13] == 1'b0) && (b_rdata[13] == 1'b0));
    // R3
    a_in_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !b_wr |=> a_rdata[3:0] == $past(a_rdata[3:0]));
    // R3
    b_in_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !a_wr |=> b_rdata[3:0] == $past(b_rdata[3:0]));
    // R4
    a_to_b_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        a_wr |=> b_rdata[3:0] == ($past(a_be[1]) ? $past(a_wdata[11:8]) : $past(a_rdata[11:8])));
    // R4
    b_to_a_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        b_wr |=> a_rdata[3:0] == ($past(b_be[1]) ? $past(b_wdata[11:8]) : $past(b_rdata[11:8])));
    // R5
    a_ring_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        a_ring |-> $past(a_wr && a_be[1] && a_wdata[13] && b_rdata[14]));
    // R5
    b_ring_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        b_ring |-> $past(b_wr && b_be[1] && b_wdata[13] && a_rdata[14]));
    // R5
    a_ring_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_wr && a_be[1] && a_wdata[13] && b_rdata[14]) |=> a_ring);

    logic unused_chk;
    assign unused_chk = ^{a_be[0], b_be[0]};
endmodule

bind ipcsync_pair ipcsync_pair_chk u_chk (.*);

// File: tb/ipcsync_pair_bench.sv
module ipcsync_pair_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        a_wr, b_wr;
    logic [1:0]  a_be, b_be;
    logic [15:0] a_wdata, b_wdata;
    logic [15:0] a_rdata, b_rdata;
    logic        a_ring, b_ring;

    always #4 clk = ~clk;

    ipcsync_pair u_ipcsync_pair (
        .clk(clk), .rst_n(rst_n),
        .a_wr(a_wr), .a_be(a_be), .a_wdata(a_wdata), .a_rdata(a_rdata), .a_ring(a_ring),
        .b_wr(b_wr), .b_be(b_be), .b_wdata(b_wdata), .b_rdata(b_rdata), .b_ring(b_ring)
    );

    int total = 0;
    int bad   = 0;

    logic       ien_m  [2];
    logic [3:0] onib_m [2];
    logic [3:0] inib_m [2];
    logic       ring_m [2];

    function automatic logic [15:0] view_m(int s);
        return {1'b0, ien_m[s], 2'b00, onib_m[s], 4'h0, inib_m[s]};
    endfunction

    function automatic logic [15:0] merge_m(logic [1:0] be, logic [15:0] wd, logic [15:0] cur);
        return {be[1] ? wd[15:8] : cur[15:8], be[0] ? wd[7:0] : cur[7:0]};
    endfunction

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int s = 0; s < 2; s++) begin
            ien_m[s] = 1'b0; onib_m[s] = 4'h0; inib_m[s] = 4'h0; ring_m[s] = 1'b0;
        end
    endtask

    // called at a negedge; returns at a negedge two cycles later
    task automatic apply(string tag, logic wa, logic wb, logic [1:0] bea, logic [1:0] beb,
                         logic [15:0] wda, logic [15:0] wdb);
        logic [15:0] ma, mb;
        logic        ien_a0, ien_b0;
        logic [15:0] hold_a, hold_b;
        ma = merge_m(bea, wda, view_m(0));
        mb = merge_m(beb, wdb, view_m(1));
        ien_a0 = ien_m[0];
        ien_b0 = ien_m[1];
        ring_m[0] = wa & ma[13] & ien_b0;
        ring_m[1] = wb & mb[13] & ien_a0;
        if (wa) begin ien_m[0] = ma[14]; onib_m[0] = ma[11:8]; inib_m[1] = ma[11:8]; end
        if (wb) begin ien_m[1] = mb[14]; onib_m[1] = mb[11:8]; inib_m[0] = mb[11:8]; end
        a_wr = wa; b_wr = wb; a_be = bea; b_be = beb; a_wdata = wda; b_wdata = wdb;
        @(posedge clk);
        @(negedge clk);
        a_wr = 1'b0; b_wr = 1'b0;
        chk({tag, " R2 a view"}, a_rdata, view_m(0));
        chk({tag, " R2 b view"}, b_rdata, view_m(1));
        chk({tag, " R3 R4 a in"}, {12'h0, a_rdata[3:0]}, {12'h0, inib_m[0]});
        chk({tag, " R4 b in"}, {12'h0, b_rdata[3:0]}, {12'h0, inib_m[1]});
        chk({tag, " R7 bit13"}, {14'h0, a_rdata[13], b_rdata[13]}, 16'h0);
        chk({tag, " R5 ring"}, {14'h0, a_ring, b_ring}, {14'h0, ring_m[0], ring_m[1]});
        hold_a = a_rdata; hold_b = b_rdata;
        ring_m[0] = 1'b0; ring_m[1] = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk({tag, " R5 ring drop"}, {14'h0, a_ring, b_ring}, 16'h0);
        chk({tag, " R3 idle hold"}, a_rdata ^ b_rdata, hold_a ^ hold_b);
    endtask

    initial begin
        #(8 * 150000);
        bad++;
        total++;
        $display("FAIL watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        a_wr = 1'b0; b_wr = 1'b0; a_be = 2'b00; b_be = 2'b00;
        a_wdata = 16'h0; b_wdata = 16'h0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 a reset", a_rdata, 16'h0);
        chk("R1 b reset", b_rdata, 16'h0);
        chk("R1 ring reset", {14'h0, a_ring, b_ring}, 16'h0);

        // single-side sweep: side x byte enables x control bits x code
        for (int s = 0; s < 2; s++) begin
            for (int be = 0; be < 4; be++) begin
                for (int ctl = 0; ctl < 4; ctl++) begin
                    for (int nib = 0; nib < 16; nib++) begin
                        logic [15:0] r, wd;
                        r  = 16'((s * 256 + be * 64 + ctl * 16 + nib) * 16'h9E37 + 16'h1234);
                        wd = {r[15], ctl[1], ctl[0], r[12], nib[3:0], r[7:0]};
                        if (s == 0)
                            apply(be == 3 ? "single" : "R6 partial", 1'b1, 1'b0,
                                  be[1:0], 2'b11, wd, 16'h0);
                        else
                            apply(be == 3 ? "single" : "R6 partial", 1'b0, 1'b1,
                                  2'b11, be[1:0], 16'h0, wd);
                    end
                end
            end
        end

        // simultaneous writes from both sides
        for (int i = 0; i < 256; i++) begin
            logic [15:0] ra, rb, wa, wb;
            ra = 16'(i * 16'h6B43 + 16'h0F0F);
            rb = 16'(i * 16'h3A97 + 16'hA5A5);
            wa = {ra[15], ra[3], ra[9], ra[12], ra[11:8] ^ 4'(i), ra[7:0]};
            wb = {rb[15], rb[5], rb[2], rb[12], rb[11:8] ^ 4'(i >> 4), rb[7:0]};
            apply("R8 both", 1'b1, 1'b1, {1'b1, ra[0]}, {(i % 5) != 0, rb[1]}, wa, wb);
        end

        // reset in the middle of activity
        apply("R5 arm", 1'b1, 1'b1, 2'b11, 2'b11, 16'h4A00, 16'h4500);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        @(negedge clk);
        chk("R1 a mid reset", a_rdata, 16'h0);
        chk("R1 b mid reset", b_rdata, 16'h0);
        apply("R5 after reset", 1'b1, 1'b0, 2'b11, 2'b11, 16'h2300, 16'h0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule